// File: doc/BRIEF.md
# Fetch-and-Op Atomic Memory Unit

This block fronts a small internal synchronous memory of 64-bit locations and carries out single-location atomic read-modify-write operations. Such operations are the building blocks of software locks, ticket counters and barriers. A requester presents an address, a direction flag (read or write), a size flag and store data on a valid/ready request channel. The block decodes the wanted operation from low address bits and reads the target location. For modifying operations it then writes the updated value back. It returns exactly one response beat with data and an error flag on a valid/ready response channel.

Read-direction operations return the value held before the update. Write-direction operations return zero data. A 64-bit location can be used as one 64-bit counter or as two independent 32-bit counters. While one operation is in flight, the request channel stays not-ready, so no other request can observe or disturb the location between the read and the write.

Top module: `amo_unit`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, and every location reads back as zero through a 64-bit plain fetch.
- R2: A request whose address bits 37:36 are not binary 10 gets an error response (rsp_err=1, rsp_rdata=0) and leaves memory unchanged.
- R3: Address bits 5:3 give the operation code. For reads (req_write=0) the codes are 000 fetch, 001 fetch-then-increment, 010 fetch-then-decrement and 011 fetch-then-clear. For writes (req_write=1) the codes are 000 store, 001 increment, 010 decrement, 011 AND with store data and 100 OR with store data. Any other code gets an error response and leaves memory unchanged.
- R4: With req_dw=1 (64-bit), address bits 2:0 must be zero. With req_dw=0 (32-bit), address bits 1:0 must be zero and bit 2 picks the upper half (1) or lower half (0) of the 64-bit location. Any other alignment gets an error response and no memory change.
- R5: The location index is taken from address bits 6 and up (IDX_W bits). Any set bit between that index field and bit 35 gets an error response and no memory change. Address bits above 37 are ignored.
- R6: Read-direction operations return the prior value: the whole 64 bits, or the selected half zero-extended into rsp_rdata[31:0]. Fetch leaves the location unchanged. The other three write back old+1, old-1 or zero.
- R7: Write-direction operations store wdata, old+1, old-1, old AND wdata, or old OR wdata, and respond with rsp_rdata=0 and rsp_err=0. In 32-bit mode the operand is req_wdata[31:0].
- R8: A 32-bit operation changes only its selected half and wraps modulo 2^32 without carry or borrow into the other half.
- R9: A 64-bit increment or decrement wraps modulo 2^64.
- R10: After a request is accepted, req_ready stays 0 until the response has been taken. Each accepted request yields exactly one response. A response held under rsp_ready=0 keeps its data and error flag stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Physical address: space field, index, operation code, half select |
| req_write | input | 1 | 1 = write-direction operation, 0 = read-direction |
| req_dw | input | 1 | 1 = 64-bit operand, 0 = 32-bit operand |
| req_wdata | input | 64 | Store data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | 64 | Prior value for read operations, else zero |
| rsp_err | output | 1 | Request was rejected |

## Verification
Every location is swept through every code in both directions, at both sizes and in both halves. Each operation starts from preloaded values sitting on the wrap boundaries: zero, all ones, the 32-bit all-ones carry edge, and the sign bit alone. Each operation is followed by a 64-bit read-back. That read-back separates a correct half-width update from one that carries, borrows or spills into the neighbouring half, and separates writes that happened from ones that must not. A further set of requests covers wrong space fields, misaligned low bits and out-of-range index bits. It shows that the rejections are told apart from legal neighbours that differ in one bit. A held response under backpressure exercises the atomic window.

// File: rtl/amo_pkg.sv
package amo_pkg;

   localparam int WORD_W = 64;
   localparam int HALF_W = 32;
   localparam int LANES  = WORD_W / HALF_W;

   typedef enum logic [3:0] {
      K_FETCH, K_FINC, K_FDEC, K_FCLR,
      K_STORE, K_INC, K_DEC, K_AND, K_OR,
      K_BAD
   } amo_kind_e;

   function automatic logic [WORD_W-1:0] amo_apply(amo_kind_e k,
                                                   logic [WORD_W-1:0] cur,
                                                   logic [WORD_W-1:0] opnd);
      logic [WORD_W-1:0] res;
      case (k)
         K_FINC, K_INC: res = cur + 1'b1;
         K_FDEC, K_DEC: res = cur - 1'b1;
         K_FCLR:        res = '0;
         K_STORE:       res = opnd;
         K_AND:         res = cur & opnd;
         K_OR:          res = cur | opnd;
         default:       res = cur;
      endcase
      return res;
   endfunction

   function automatic logic amo_modifies(amo_kind_e k);
      return (k != K_FETCH) && (k != K_BAD);
   endfunction

   function automatic logic amo_returns(amo_kind_e k);
      return (k == K_FETCH) || (k == K_FINC) || (k == K_FDEC) || (k == K_FCLR);
   endfunction

endpackage

// File: rtl/amo_decode.sv
module amo_decode
   import amo_pkg::*;
#(
   parameter int ADDR_W = 40,
   parameter int IDX_W  = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              is_write,
   input  logic              dw,
   output amo_kind_e         kind,
   output logic              half,
   output logic [IDX_W-1:0]  idx,
   output logic              err
);
   localparam int IDX_LO  = 6;
   localparam int IDX_HI  = IDX_LO + IDX_W;
   localparam int OFS_TOP = 35;

   logic space_bad, align_bad, range_bad;

   always_comb begin
      case ({is_write, addr[5:3]})
         4'b0_000: kind = K_FETCH;
         4'b0_001: kind = K_FINC;
         4'b0_010: kind = K_FDEC;
         4'b0_011: kind = K_FCLR;
         4'b1_000: kind = K_STORE;
         4'b1_001: kind = K_INC;
         4'b1_010: kind = K_DEC;
         4'b1_011: kind = K_AND;
         4'b1_100: kind = K_OR;
         default:  kind = K_BAD;
      endcase
   end

   assign space_bad = (addr[37:36] != 2'b10);
   assign align_bad = dw ? (addr[2:0] != 3'b000) : (addr[1:0] != 2'b00);
   assign half      = addr[2];
   assign idx       = addr[IDX_LO +: IDX_W];

   generate
      if (IDX_HI <= OFS_TOP) begin : g_range
         assign range_bad = |addr[OFS_TOP:IDX_HI];
      end else begin : g_full
         assign range_bad = 1'b0;
      end
   endgenerate

   assign err = space_bad | align_bad | range_bad | (kind == K_BAD);

endmodule

// File: rtl/amo_alu.sv
module amo_alu
   import amo_pkg::*;
(
   input  amo_kind_e          kind,
   input  logic               dw,
   input  logic               half,
   input  logic [WORD_W-1:0]  old_val,
   input  logic [WORD_W-1:0]  opnd,
   output logic [WORD_W-1:0]  new_val,
   output logic [LANES-1:0]   lane_we,
   output logic [WORD_W-1:0]  ret_val
);
   logic [HALF_W-1:0] old_half;
   logic [WORD_W-1:0] full_res;
   logic [WORD_W-1:0] narrow_ext;
   logic [HALF_W-1:0] narrow_res;

   assign old_half   = half ? old_val[WORD_W-1:HALF_W] : old_val[HALF_W-1:0];
   assign full_res   = amo_apply(kind, old_val, opnd);
   assign narrow_ext = amo_apply(kind, {{(WORD_W-HALF_W){1'b0}}, old_half},
                                 {{(WORD_W-HALF_W){1'b0}}, opnd[HALF_W-1:0]});
   assign narrow_res = narrow_ext[HALF_W-1:0];

   always_comb begin
      if (dw) begin
         new_val = full_res;
         lane_we = amo_modifies(kind) ? {LANES{1'b1}} : '0;
         ret_val = amo_returns(kind) ? old_val : '0;
      end else begin
         new_val = {narrow_res, narrow_res};
         lane_we = '0;
         if (amo_modifies(kind)) lane_we[half] = 1'b1;
         ret_val = amo_returns(kind) ? {{(WORD_W-HALF_W){1'b0}}, old_half} : '0;
      end
   end

endmodule

// File: rtl/amo_store.sv
module amo_store
   import amo_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] rd_data,
   input  logic [LANES-1:0]  wr_lane,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_data
);
   localparam int DEPTH = 1 << IDX_W;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [HALF_W-1:0] cells [DEPTH];
         logic [HALF_W-1:0] rd_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
               rd_q <= '0;
            end else begin
               if (wr_lane[g]) cells[wr_idx] <= wr_data[g*HALF_W +: HALF_W];
               if (rd_en)      rd_q <= cells[rd_idx];
            end
         end

         assign rd_data[g*HALF_W +: HALF_W] = rd_q;
      end
   endgenerate

endmodule

// File: rtl/amo_unit.sv
module amo_unit
   import amo_pkg::*;
#(
   parameter int ADDR_W = 40,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_dw,
   input  logic [63:0]       req_wdata,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [63:0]       rsp_rdata,
   output logic              rsp_err
);
   generate
      if (ADDR_W < 38) begin : g_chk_addr
         $error("amo_unit: ADDR_W must cover the space field at bits 37:36");
      end
      if (IDX_W < 1 || IDX_W > 12) begin : g_chk_idx
         $error("amo_unit: IDX_W must be between 1 and 12");
      end
   endgenerate

   typedef enum logic [1:0] {S_IDLE, S_READ, S_RESP} state_e;

   state_e            state;
   amo_kind_e         dec_kind, cur_kind;
   logic              dec_half, dec_err;
   logic [IDX_W-1:0]  dec_idx, cur_idx;
   logic              cur_dw, cur_half, cur_write;
   logic [63:0]       cur_wdata;
   logic              accept;
   logic [63:0]       ram_rdata, alu_new, alu_ret;
   logic [LANES-1:0]  alu_we, ram_we;
   logic [63:0]       rsp_rdata_q;
   logic              rsp_err_q;

   assign req_ready = (state == S_IDLE);
   assign accept    = req_valid & req_ready;
   assign rsp_valid = (state == S_RESP);
   assign rsp_rdata = rsp_rdata_q;
   assign rsp_err   = rsp_err_q;

   amo_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
      .addr(req_addr), .is_write(req_write), .dw(req_dw),
      .kind(dec_kind), .half(dec_half), .idx(dec_idx), .err(dec_err)
   );

   amo_alu u_alu (
      .kind(cur_kind), .dw(cur_dw), .half(cur_half),
      .old_val(ram_rdata), .opnd(cur_wdata),
      .new_val(alu_new), .lane_we(alu_we), .ret_val(alu_ret)
   );

   assign ram_we = (state == S_READ) ? alu_we : '0;

   amo_store #(.IDX_W(IDX_W)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .rd_en(accept & ~dec_err), .rd_idx(dec_idx), .rd_data(ram_rdata),
      .wr_lane(ram_we), .wr_idx(cur_idx), .wr_data(alu_new)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= S_IDLE;
         cur_kind    <= K_FETCH;
         cur_idx     <= '0;
         cur_dw      <= 1'b0;
         cur_half    <= 1'b0;
         cur_write   <= 1'b0;
         cur_wdata   <= '0;
         rsp_rdata_q <= '0;
         rsp_err_q   <= 1'b0;
      end else begin
         case (state)
            S_IDLE: if (accept) begin
               cur_kind  <= dec_kind;
               cur_idx   <= dec_idx;
               cur_dw    <= req_dw;
               cur_half  <= dec_half;
               cur_write <= req_write;
               cur_wdata <= req_wdata;
               if (dec_err) begin
                  rsp_rdata_q <= '0;
                  rsp_err_q   <= 1'b1;
                  state       <= S_RESP;
               end else begin
                  state       <= S_READ;
               end
            end
            S_READ: begin
               rsp_rdata_q <= alu_ret;
               rsp_err_q   <= 1'b0;
               state       <= S_RESP;
            end
            S_RESP: if (rsp_ready) state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_ready,
   input logic        rsp_valid,
   input logic        rsp_ready,
   input logic [63:0] rsp_rdata,
   input logic        rsp_err,
   input logic [1:0]  ram_we,
   input logic        cur_write,
   input logic        cur_dw
);
   // R10: an accepted request closes the request channel on the next cycle
   a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R10: a stalled response holds its contents
   a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

   // R10: never accepting while a response is outstanding
   a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   // R7: write-direction responses carry no data
   a_r7_write_no_data: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && cur_write) |-> (rsp_rdata == 64'd0));

   // R8: a 32-bit operation touches at most one half
   a_r8_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
      !cur_dw |-> ($countones(ram_we) <= 1));

   // R2: no memory write while idle, so rejected requests never write
   a_r2_no_idle_write: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (ram_we == 2'b00));

   // R2: error responses carry zero data
   a_r2_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_rdata == 64'd0));
endmodule

bind amo_unit amo_unit_chk u_chk (
   .clk(clk), .rst_n(rst_n),
   .req_valid(req_valid), .req_ready(req_ready),
   .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
   .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
   .ram_we(ram_we), .cur_write(cur_write), .cur_dw(cur_dw)
);

// File: tb/amo_unit_test.sv
`timescale 1ns/1ps
module amo_unit_test;
   localparam int AW = 40;
   localparam int IW = 2;
   localparam int NLOC = 1 << IW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [AW-1:0] req_addr = '0;
   logic req_write = 1'b0;
   logic req_dw = 1'b0;
   logic [63:0] req_wdata = '0;
   logic rsp_valid;
   logic rsp_ready = 1'b1;
   logic [63:0] rsp_rdata;
   logic rsp_err;

   int checks = 0;
   int errors = 0;
   logic [63:0] model [NLOC];

   always #5 clk = ~clk;

   amo_unit #(.ADDR_W(AW), .IDX_W(IW)) uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_write(req_write), .req_dw(req_dw), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
   );

   function automatic logic [AW-1:0] mk_addr(logic [1:0] sp, int idx, logic [2:0] op,
                                             logic hf, logic [1:0] low);
      logic [AW-1:0] a;
      a = '0;
      a[37:36] = sp;
      a[6 +: IW] = idx[IW-1:0];
      a[5:3] = op;
      a[2] = hf;
      a[1:0] = low;
      a[39] = 1'b1;           // above the space field: ignored (R5)
      return a;
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Issue one request, compare against the bench's own reference model.
   task automatic issue(logic [AW-1:0] a, logic wr, logic dw, logic [63:0] wd,
                        int stall, string req);
      logic [2:0] op;
      logic hf, bad;
      int ix;
      logic [63:0] old, nv, exp_d;
      logic [31:0] o32, n32;
      op = a[5:3]; hf = a[2]; ix = int'(a[6 +: IW]);
      bad = (a[37:36] != 2'b10) || (dw ? (a[2:0] != 0) : (a[1:0] != 0))
            || (a[35:6+IW] != 0) || (wr ? (op > 3'd4) : (op > 3'd3));
      exp_d = '0;
      if (!bad) begin
         old = model[ix];
         o32 = hf ? old[63:32] : old[31:0];
         if (dw) begin
            case ({wr, op})
               4'b0001, 4'b1001: nv = old + 64'd1;
               4'b0010, 4'b1010: nv = old - 64'd1;
               4'b0011:          nv = 64'd0;
               4'b1000:          nv = wd;
               4'b1011:          nv = old & wd;
               4'b1100:          nv = old | wd;
               default:          nv = old;
            endcase
            if (!wr) exp_d = old;
         end else begin
            case ({wr, op})
               4'b0001, 4'b1001: n32 = o32 + 32'd1;
               4'b0010, 4'b1010: n32 = o32 - 32'd1;
               4'b0011:          n32 = 32'd0;
               4'b1000:          n32 = wd[31:0];
               4'b1011:          n32 = o32 & wd[31:0];
               4'b1100:          n32 = o32 | wd[31:0];
               default:          n32 = o32;
            endcase
            nv = hf ? {n32, old[31:0]} : {old[63:32], n32};
            if (!wr) exp_d = {32'd0, o32};
         end
         model[ix] = nv;
      end
      @(negedge clk);
      req_addr = a; req_write = wr; req_dw = dw; req_wdata = wd; req_valid = 1'b1;
      rsp_ready = (stall == 0);
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check({"R10 busy after accept ", req}, {63'd0, req_ready}, 64'd0);
      while (!rsp_valid) @(negedge clk);
      if (stall > 0) begin
         logic [63:0] first_d;
         first_d = rsp_rdata;
         repeat (stall) @(negedge clk);
         check({"R10 held response ", req}, {rsp_valid, rsp_rdata[62:0]}, {1'b1, first_d[62:0]});
         rsp_ready = 1'b1;
      end
      check({req, " data"}, rsp_rdata, exp_d);
      check({req, " error"}, {63'd0, rsp_err}, {63'd0, bad});
      @(negedge clk);
   endtask

   task automatic readback(int ix, string req);
      issue(mk_addr(2'b10, ix, 3'd0, 1'b0, 2'b00), 1'b0, 1'b1, 64'd0, 0, req);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      logic [63:0] pats [4];
      pats[0] = 64'd0;
      pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
      pats[2] = 64'h0000_0000_FFFF_FFFF;
      pats[3] = 64'h8000_0000_0000_0000;
      for (int i = 0; i < NLOC; i++) model[i] = 64'd0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 req_ready after reset", {63'd0, req_ready}, 64'd1);
      check("R1 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
      for (int i = 0; i < NLOC; i++) readback(i, "R1 zero after reset");

      // R3 R6 R7 R8 R9: full sweep of codes, sizes, halves and boundary values
      for (int ix = 0; ix < NLOC; ix++)
         for (int dw = 0; dw < 2; dw++)
            for (int hf = 0; hf < 2 - dw; hf++)
               for (int wr = 0; wr < 2; wr++)
                  for (int op = 0; op < 8; op++)
                     for (int p = 0; p < 4; p++) begin
                        issue(mk_addr(2'b10, ix, 3'd0, 1'b0, 2'b00), 1'b1, 1'b1,
                              pats[p], 0, "R7 preload");
                        issue(mk_addr(2'b10, ix, 3'(op), 1'(hf), 2'b00), 1'(wr), 1'(dw),
                              ~pats[p] ^ 64'h0F0F_3C3C_5A5A_A5A5, 0,
                              "R3 R6 R7 R8 R9 op under test");
                        readback(ix, "R8 R9 readback");
                     end

      // R2: wrong space field
      for (int sp = 0; sp < 4; sp++) if (sp != 2) begin
         issue(mk_addr(2'(sp), 1, 3'd1, 1'b0, 2'b00), 1'b1, 1'b1, 64'd0, 0, "R2 bad space");
         readback(1, "R2 unchanged");
      end
      // R4: misalignment at both sizes
      for (int lo = 1; lo < 4; lo++) begin
         issue(mk_addr(2'b10, 2, 3'd1, 1'b0, 2'(lo)), 1'b1, 1'b0, 64'd0, 0, "R4 bad 32-bit align");
         issue(mk_addr(2'b10, 2, 3'd3, 1'b0, 2'(lo)), 1'b0, 1'b1, 64'd0, 0, "R4 bad 64-bit align");
      end
      issue(mk_addr(2'b10, 2, 3'd1, 1'b1, 2'b00), 1'b1, 1'b1, 64'd0, 0, "R4 bit2 set at 64-bit");
      readback(2, "R4 unchanged");
      // R5: index bits beyond the memory
      begin
         logic [AW-1:0] a;
         a = mk_addr(2'b10, 3, 3'd1, 1'b0, 2'b00);
         a[6+IW] = 1'b1;
         issue(a, 1'b1, 1'b1, 64'd0, 0, "R5 out of range low");
         a = mk_addr(2'b10, 3, 3'd1, 1'b0, 2'b00);
         a[35] = 1'b1;
         issue(a, 1'b0, 1'b1, 64'd0, 0, "R5 out of range high");
         readback(3, "R5 unchanged");
      end
      // R10: backpressure on a fetch-then-increment and a write
      issue(mk_addr(2'b10, 0, 3'd1, 1'b0, 2'b00), 1'b0, 1'b1, 64'd0, 3, "R10 stalled read");
      issue(mk_addr(2'b10, 0, 3'd4, 1'b1, 2'b00), 1'b1, 1'b0, 64'h55, 2, "R10 stalled write");
      readback(0, "R10 readback");

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule